// File: doc/BRIEF.md
# ECC-Segment Program-Once Tracker

This block guards the program path of a flash array built from 128-bit pages. Each page holds four 32-bit words. Error-correction check bits cover 64-bit segments, so every page has two segments. Once a segment has been programmed, its check bits are final. The tracker keeps one "programmed" bit for every segment in every block. It refuses any program that would touch a segment a second time before that segment's block has been erased.

Software stages an operation with an interlock write, which latches the target block, the page and a 4-bit word mask. A go strobe then runs either a program or an erase. A program is judged within the cycle and its verdict is registered. It fails if any of these holds:
- the target block is locked;
- the target block does not exist;
- the mask is empty;
- the mask touches a segment that is already programmed.

An erase clears the tracking of every selected block that is unlocked and present. It does this whatever address the interlock write named. Both kinds of operation report completion with a one-cycle done pulse.

A go strobe that arrives in the same cycle as an interlock write is ignored. The cell array and the check-bit encoder are not part of this block.

Top module: `ecc_seg_tracker`

## Requirements
- R1: After reset, done, fail, partial_warn and seq_err are low and every segment is unprogrammed.
- R2: A go with cmd_erase=0 after an interlock write programs the touched segments. In the ilk_mask encoding, bit i selects word i of the page, bits 1:0 form segment 0 and bits 3:2 form segment 1. done is high for exactly the one cycle after the go edge, and fail stays low when the program is accepted.
- R3: A program that touches an already-programmed segment sets fail and still pulses done. The other segment of the same page remains programmable.
- R4: A program whose mask covers exactly one word of a segment (mask pair 01 or 10) is accepted and sets partial_warn.
- R5: After a single-word program, a later program to the adjoining word of that segment fails.
- R6: A program to a block that is locked (blk_lock bit 1) or absent (blk_exists bit 0) is still latched and pulses done. It sets fail and leaves the tracking unchanged.
- R7: A go with cmd_erase=1 clears every segment of each block that is selected, unlocked and present. It pulses done and never sets fail, even when the interlock address names an absent block. Locked, unselected and absent blocks keep their state.
- R8: A go with no interlock write since the last accepted go produces no done. It sets seq_err and changes no tracking.
- R9: fail, partial_warn and seq_err hold their value until the next interlock write, which clears all three.
- R10: A program with an all-zero word mask fails.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ilk_we | input | 1 | Interlock write strobe |
| ilk_blk | input | BLK_W | Target block of the interlock write |
| ilk_page | input | PG_W | Target page within the block |
| ilk_mask | input | 4 | Word mask, bit i = word i of the page |
| cmd_go | input | 1 | Start the staged operation |
| cmd_erase | input | 1 | Operation kind sampled with cmd_go: 1 erase, 0 program |
| blk_lock | input | NUM_BLOCKS | Per-block lock |
| blk_sel | input | NUM_BLOCKS | Per-block erase select |
| blk_exists | input | NUM_BLOCKS | Per-block presence map |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Program rejected, held until next interlock write |
| partial_warn | output | 1 | Single-word segment program accepted, held |
| seq_err | output | 1 | Go without interlock, held |

## Verification
Every result is registered once. done, fail, partial_warn and seq_err change on the rising edge that samples cmd_go, and the clearing of the status flags lands on the edge that samples ilk_we. The bench drives each strobe for a single cycle starting at a falling edge. It reads the outputs at the next falling edge, which is half a period after the edge that registered them. It reads once more a cycle later to confirm that done has fallen and that the flags are still held. Tracking state has no output of its own, so the bench observes it through the verdict of a later program to the same segment.

// File: rtl/ecc_trk_pkg.sv
package ecc_trk_pkg;
   localparam int WORDS_PER_PAGE = 4;
   localparam int WORDS_PER_SEG  = 2;
   localparam int SEGS_PER_PAGE  = WORDS_PER_PAGE / WORDS_PER_SEG;

   typedef enum logic {
      OP_PROGRAM = 1'b0,
      OP_ERASE   = 1'b1
   } trk_op_e;

   // segment s is touched when any of its words is in the mask
   function automatic logic [SEGS_PER_PAGE-1:0] seg_touch(input logic [WORDS_PER_PAGE-1:0] m);
      logic [SEGS_PER_PAGE-1:0] t;
      for (int s = 0; s < SEGS_PER_PAGE; s++)
         t[s] = |m[s*WORDS_PER_SEG +: WORDS_PER_SEG];
      return t;
   endfunction

   // segment s is partially covered when some but not all of its words are set
   function automatic logic seg_partial(input logic [WORDS_PER_PAGE-1:0] m);
      logic p;
      p = 1'b0;
      for (int s = 0; s < SEGS_PER_PAGE; s++)
         p |= (|m[s*WORDS_PER_SEG +: WORDS_PER_SEG]) & ~(&m[s*WORDS_PER_SEG +: WORDS_PER_SEG]);
      return p;
   endfunction
endpackage

// File: rtl/ecc_trk_ilk.sv
module ecc_trk_ilk #(
   parameter int BLK_W = 2,
   parameter int PG_W  = 3
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  wr_en,
   input  logic [BLK_W-1:0]                      wr_blk,
   input  logic [PG_W-1:0]                       wr_pg,
   input  logic [ecc_trk_pkg::WORDS_PER_PAGE-1:0] wr_mask,
   input  logic                                  consume,
   output logic [BLK_W-1:0]                      lat_blk,
   output logic [PG_W-1:0]                       lat_pg,
   output logic [ecc_trk_pkg::WORDS_PER_PAGE-1:0] lat_mask,
   output logic                                  armed
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lat_blk  <= '0;
         lat_pg   <= '0;
         lat_mask <= '0;
         armed    <= 1'b0;
      end else if (wr_en) begin
         lat_blk  <= wr_blk;
         lat_pg   <= wr_pg;
         lat_mask <= wr_mask;
         armed    <= 1'b1;
      end else if (consume) begin
         armed    <= 1'b0;
      end
   end
endmodule

// File: rtl/ecc_trk_store.sv
module ecc_trk_store #(
   parameter int NUM_BLOCKS      = 4,
   parameter int PAGES_PER_BLOCK = 8
) (
   input  logic                                          clk,
   input  logic                                          rst_n,
   input  logic                                          set_en,
   input  logic [$clog2(NUM_BLOCKS)-1:0]                 set_blk,
   input  logic [$clog2(PAGES_PER_BLOCK)-1:0]            set_pg,
   input  logic [ecc_trk_pkg::SEGS_PER_PAGE-1:0]         set_segs,
   input  logic [NUM_BLOCKS-1:0]                         clr_blks,
   input  logic [$clog2(NUM_BLOCKS)-1:0]                 rd_blk,
   input  logic [$clog2(PAGES_PER_BLOCK)-1:0]            rd_pg,
   output logic [ecc_trk_pkg::SEGS_PER_PAGE-1:0]         rd_segs
);
   localparam int SPP          = ecc_trk_pkg::SEGS_PER_PAGE;
   localparam int SEGS_PER_BLK = PAGES_PER_BLOCK * SPP;
   localparam int BLK_W        = $clog2(NUM_BLOCKS);

   logic [SEGS_PER_BLK-1:0] blk_bits [NUM_BLOCKS];

   for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_blk
      logic [SEGS_PER_BLK-1:0] bits;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            bits <= '0;
         else if (clr_blks[b])
            bits <= '0;
         else if (set_en && (set_blk == BLK_W'(b)))
            bits[set_pg*SPP +: SPP] <= bits[set_pg*SPP +: SPP] | set_segs;
      end
      assign blk_bits[b] = bits;
   end

   assign rd_segs = blk_bits[rd_blk][rd_pg*SPP +: SPP];
endmodule

// File: rtl/ecc_trk_eval.sv
module ecc_trk_eval #(
   parameter int NUM_BLOCKS      = 4,
   parameter bit PARTIAL_WARN_EN = 1'b1
) (
   input  logic [$clog2(NUM_BLOCKS)-1:0]          tgt_blk,
   input  logic [ecc_trk_pkg::WORDS_PER_PAGE-1:0] tgt_mask,
   input  logic [ecc_trk_pkg::SEGS_PER_PAGE-1:0]  cur_segs,
   input  logic [NUM_BLOCKS-1:0]                  blk_lock,
   input  logic [NUM_BLOCKS-1:0]                  blk_sel,
   input  logic [NUM_BLOCKS-1:0]                  blk_exists,
   output logic [ecc_trk_pkg::SEGS_PER_PAGE-1:0]  touch_segs,
   output logic                                   reject,
   output logic                                   partial,
   output logic [NUM_BLOCKS-1:0]                  erase_blks
);
   logic blocked;
   logic overlap;
   logic empty;

   always_comb begin
      touch_segs = ecc_trk_pkg::seg_touch(tgt_mask);
      blocked    = blk_lock[tgt_blk] | ~blk_exists[tgt_blk];
      overlap    = |(touch_segs & cur_segs);
      empty      = ~|tgt_mask;
      reject     = blocked | overlap | empty;
      erase_blks = blk_sel & ~blk_lock & blk_exists;
   end

   if (PARTIAL_WARN_EN) begin : g_warn
      assign partial = ecc_trk_pkg::seg_partial(tgt_mask);
   end else begin : g_nowarn
      assign partial = 1'b0;
   end
endmodule

// File: rtl/ecc_seg_tracker.sv
module ecc_seg_tracker #(
   parameter int NUM_BLOCKS      = 4,
   parameter int PAGES_PER_BLOCK = 8,
   parameter bit PARTIAL_WARN_EN = 1'b1,
   localparam int BLK_W = $clog2(NUM_BLOCKS),
   localparam int PG_W  = $clog2(PAGES_PER_BLOCK)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  ilk_we,
   input  logic [BLK_W-1:0]      ilk_blk,
   input  logic [PG_W-1:0]       ilk_page,
   input  logic [3:0]            ilk_mask,
   input  logic                  cmd_go,
   input  logic                  cmd_erase,
   input  logic [NUM_BLOCKS-1:0] blk_lock,
   input  logic [NUM_BLOCKS-1:0] blk_sel,
   input  logic [NUM_BLOCKS-1:0] blk_exists,
   output logic                  done,
   output logic                  fail,
   output logic                  partial_warn,
   output logic                  seq_err
);
   import ecc_trk_pkg::*;

   if (NUM_BLOCKS < 2 || (NUM_BLOCKS & (NUM_BLOCKS - 1)) != 0) begin : g_bad_blocks
      $error("NUM_BLOCKS must be a power of two and at least 2");
   end
   if (PAGES_PER_BLOCK < 2 || (PAGES_PER_BLOCK & (PAGES_PER_BLOCK - 1)) != 0) begin : g_bad_pages
      $error("PAGES_PER_BLOCK must be a power of two and at least 2");
   end
   if (WORDS_PER_PAGE != 4) begin : g_bad_words
      $error("word mask width is fixed at 4");
   end

   logic [BLK_W-1:0]          lat_blk;
   logic [PG_W-1:0]           lat_pg;
   logic [WORDS_PER_PAGE-1:0] lat_mask;
   logic                      armed_q;
   logic [SEGS_PER_PAGE-1:0]  cur_segs;
   logic [SEGS_PER_PAGE-1:0]  touch_segs;
   logic                      prog_reject;
   logic                      partial;
   logic [NUM_BLOCKS-1:0]     erase_blks;
   trk_op_e                   op;
   logic                      go_ok;
   logic                      go_orphan;
   logic                      prog_go;
   logic                      erase_go;

   always_comb begin
      op        = trk_op_e'(cmd_erase);
      go_ok     = cmd_go & ~ilk_we & armed_q;
      go_orphan = cmd_go & ~ilk_we & ~armed_q;
      prog_go   = go_ok & (op == OP_PROGRAM);
      erase_go  = go_ok & (op == OP_ERASE);
   end

   ecc_trk_ilk #(.BLK_W(BLK_W), .PG_W(PG_W)) u_ilk (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (ilk_we),
      .wr_blk   (ilk_blk),
      .wr_pg    (ilk_page),
      .wr_mask  (ilk_mask),
      .consume  (go_ok),
      .lat_blk  (lat_blk),
      .lat_pg   (lat_pg),
      .lat_mask (lat_mask),
      .armed    (armed_q)
   );

   ecc_trk_eval #(.NUM_BLOCKS(NUM_BLOCKS), .PARTIAL_WARN_EN(PARTIAL_WARN_EN)) u_eval (
      .tgt_blk    (lat_blk),
      .tgt_mask   (lat_mask),
      .cur_segs   (cur_segs),
      .blk_lock   (blk_lock),
      .blk_sel    (blk_sel),
      .blk_exists (blk_exists),
      .touch_segs (touch_segs),
      .reject     (prog_reject),
      .partial    (partial),
      .erase_blks (erase_blks)
   );

   ecc_trk_store #(.NUM_BLOCKS(NUM_BLOCKS), .PAGES_PER_BLOCK(PAGES_PER_BLOCK)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_en   (prog_go & ~prog_reject),
      .set_blk  (lat_blk),
      .set_pg   (lat_pg),
      .set_segs (touch_segs),
      .clr_blks (erase_go ? erase_blks : '0),
      .rd_blk   (lat_blk),
      .rd_pg    (lat_pg),
      .rd_segs  (cur_segs)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done         <= 1'b0;
         fail         <= 1'b0;
         partial_warn <= 1'b0;
         seq_err      <= 1'b0;
      end else begin
         done <= go_ok;
         if (ilk_we) begin
            fail         <= 1'b0;
            partial_warn <= 1'b0;
            seq_err      <= 1'b0;
         end else begin
            if (prog_go && prog_reject)             fail         <= 1'b1;
            if (prog_go && !prog_reject && partial) partial_warn <= 1'b1;
            if (go_orphan)                          seq_err      <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/ecc_seg_tracker_chk.sv
module ecc_seg_tracker_chk (
   input logic clk,
   input logic rst_n,
   input logic ilk_we,
   input logic cmd_go,
   input logic cmd_erase,
   input logic armed,
   input logic prog_reject,
   input logic done,
   input logic fail,
   input logic partial_warn,
   input logic seq_err
);
   // R2
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R2
   done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(cmd_go && armed && !ilk_we));

   // R3
   reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_go && !ilk_we && armed && !cmd_erase && prog_reject) |=> (fail && done));

   // R7
   erase_nofail_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_go && !ilk_we && armed && cmd_erase) |=> $stable(fail));

   // R8
   orphan_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_go && !ilk_we && !armed) |=> (seq_err && !done));

   // R9
   flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ilk_we |=> (!fail && !partial_warn && !seq_err));

   // R9
   fail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fail && !ilk_we) |=> fail);
endmodule

bind ecc_seg_tracker ecc_seg_tracker_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .ilk_we       (ilk_we),
   .cmd_go       (cmd_go),
   .cmd_erase    (cmd_erase),
   .armed        (armed_q),
   .prog_reject  (prog_reject),
   .done         (done),
   .fail         (fail),
   .partial_warn (partial_warn),
   .seq_err      (seq_err)
);

// File: tb/ecc_seg_tracker_tb.sv
module ecc_seg_tracker_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ilk_we = 1'b0;
   logic [1:0] ilk_blk = '0;
   logic [2:0] ilk_page = '0;
   logic [3:0] ilk_mask = '0;
   logic       cmd_go = 1'b0;
   logic       cmd_erase = 1'b0;
   logic [3:0] blk_lock = '0;
   logic [3:0] blk_sel = '0;
   logic [3:0] blk_exists = 4'b1111;
   logic       done, fail, partial_warn, seq_err;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   ecc_seg_tracker u_dut (
      .clk(clk), .rst_n(rst_n), .ilk_we(ilk_we), .ilk_blk(ilk_blk), .ilk_page(ilk_page),
      .ilk_mask(ilk_mask), .cmd_go(cmd_go), .cmd_erase(cmd_erase), .blk_lock(blk_lock),
      .blk_sel(blk_sel), .blk_exists(blk_exists), .done(done), .fail(fail),
      .partial_warn(partial_warn), .seq_err(seq_err)
   );

   task automatic chk(input string tag, input string what, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   task automatic ilk(input logic [1:0] b, input logic [2:0] p, input logic [3:0] m);
      @(negedge clk);
      ilk_we = 1'b1; ilk_blk = b; ilk_page = p; ilk_mask = m;
      @(negedge clk);
      ilk_we = 1'b0;
   endtask

   task automatic go(input logic erase);
      @(negedge clk);
      cmd_go = 1'b1; cmd_erase = erase;
      @(negedge clk);
      cmd_go = 1'b0; cmd_erase = 1'b0;
   endtask

   task automatic prog(input string tag, input logic [1:0] b, input logic [2:0] p,
                       input logic [3:0] m, input logic exp_fail, input logic exp_warn);
      ilk(b, p, m);
      go(1'b0);
      chk(tag, "done", done, 1'b1);
      chk(tag, "fail", fail, exp_fail);
      chk(tag, "partial_warn", partial_warn, exp_warn);
   endtask

   task automatic t_reset();
      chk("R1", "done after reset", done, 1'b0);
      chk("R1", "fail after reset", fail, 1'b0);
      chk("R1", "partial_warn after reset", partial_warn, 1'b0);
      chk("R1", "seq_err after reset", seq_err, 1'b0);
   endtask

   task automatic t_prog_basic();
      prog("R2", 2'd0, 3'd0, 4'b1111, 1'b0, 1'b0);   // R1 fresh segments accepted
      @(negedge clk);
      chk("R2", "done one cycle only", done, 1'b0);
   endtask

   task automatic t_orphan();
      blk_sel = 4'b1111;
      go(1'b1);
      chk("R8", "no done on orphan go", done, 1'b0);
      chk("R8", "seq_err set", seq_err, 1'b1);
      blk_sel = 4'b0000;
      prog("R8", 2'd0, 3'd0, 4'b0011, 1'b1, 1'b0);   // not erased
   endtask

   task automatic t_double();
      prog("R3", 2'd0, 3'd1, 4'b1100, 1'b0, 1'b0);
      prog("R3", 2'd0, 3'd1, 4'b1000, 1'b1, 1'b0);
      prog("R3", 2'd0, 3'd1, 4'b0011, 1'b0, 1'b0);   // other segment free
      prog("R3", 2'd1, 3'd2, 4'b1111, 1'b0, 1'b0);
   endtask

   task automatic t_partial();
      prog("R4", 2'd2, 3'd0, 4'b0001, 1'b0, 1'b1);
      prog("R5", 2'd2, 3'd0, 4'b0010, 1'b1, 1'b0);
   endtask

   task automatic t_hold();
      repeat (3) @(negedge clk);
      chk("R9", "fail held", fail, 1'b1);
      ilk(2'd3, 3'd7, 4'b1111);
      chk("R9", "fail cleared by interlock", fail, 1'b0);
      chk("R9", "partial_warn cleared", partial_warn, 1'b0);
      prog("R9", 2'd3, 3'd6, 4'b0100, 1'b0, 1'b1);
      repeat (2) @(negedge clk);
      chk("R9", "partial_warn held", partial_warn, 1'b1);
   endtask

   task automatic t_blocked();
      blk_lock = 4'b1000;
      prog("R6", 2'd3, 3'd0, 4'b1111, 1'b1, 1'b0);
      blk_lock = 4'b0000;
      prog("R6", 2'd3, 3'd0, 4'b1111, 1'b0, 1'b0);   // unchanged by locked try
      blk_exists = 4'b0111;
      prog("R6", 2'd3, 3'd1, 4'b1111, 1'b1, 1'b0);
      blk_exists = 4'b1111;
      prog("R6", 2'd3, 3'd1, 4'b1111, 1'b0, 1'b0);
   endtask

   task automatic t_empty();
      prog("R10", 2'd0, 3'd6, 4'b0000, 1'b1, 1'b0);
   endtask

   task automatic t_erase();
      blk_exists = 4'b0111;
      blk_sel    = 4'b1011;
      blk_lock   = 4'b0010;
      ilk(2'd3, 3'd0, 4'b0000);     // interlock names an absent block
      go(1'b1);
      chk("R7", "erase done", done, 1'b1);
      chk("R7", "erase no fail", fail, 1'b0);
      blk_exists = 4'b1111; blk_sel = 4'b0000; blk_lock = 4'b0000;
      prog("R7", 2'd0, 3'd0, 4'b1111, 1'b0, 1'b0);   // erased
      prog("R7", 2'd1, 3'd2, 4'b0011, 1'b1, 1'b0);   // locked kept
      prog("R7", 2'd2, 3'd0, 4'b0011, 1'b1, 1'b0);   // unselected kept
      prog("R7", 2'd3, 3'd0, 4'b1111, 1'b1, 1'b0);   // absent kept
      blk_sel = 4'b1111;
      ilk(2'd0, 3'd0, 4'b1111);
      go(1'b1);
      chk("R7", "full erase done", done, 1'b1);
      blk_sel = 4'b0000;
      prog("R7", 2'd3, 3'd0, 4'b1111, 1'b0, 1'b0);
      prog("R7", 2'd1, 3'd2, 4'b1111, 1'b0, 1'b0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_prog_basic();
      t_orphan();
      t_double();
      t_partial();
      t_hold();
      t_blocked();
      t_empty();
      t_erase();
      finish_run();
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end
endmodule